// File: doc/BRIEF.md
# Converter Sample Port Splitter

This block sits behind a high-speed converter core and routes each 8-bit digital sample, one per rising edge of the conversion clock, to one or two output ports. With the mode input high, every sample leaves on port A at the full clock rate. With the mode input low, consecutive samples alternate between port A and port B, so each port only has to be captured by downstream logic at half the conversion rate.

The alternation is driven by an internal divide-by-two phase whose starting value after reset is not guaranteed; the parameter `PHASE_INIT` stands in for that unknown start. A falling edge on the sync input pins the phase, so that the next sample goes to port A and the one after to port B. A sync that agrees with the running phase has no effect, so a steady half-rate sync pulse train can be applied. A sync that disagrees realigns the phase, and one sample on each port is then flagged as corrupt through a per-port valid output. The delay from capture to output differs between the two modes.

Top module: `adc_port_demux`

## Requirements
- R1: While reset is high and until the first sample reaches a port, `a_data`, `b_data`, `a_valid` and `b_valid` are all zero.
- R2: With `single_mode` high, the sample present on `din` at rising edge k is on `a_data` with `a_valid` high from rising edge k+4 until edge k+5.
- R3: With `single_mode` high, `b_data` and `b_valid` keep their value.
- R4: With `single_mode` high, activity on `sync_in` has no effect on port A data or valid.
- R5: With `single_mode` low, the sample present at edge k appears on its port from edge k+5; the other port keeps its previous value during that cycle.
- R6: With `single_mode` low and no realignment, the ports take turns: each port updates on every second edge and never on two edges in a row.
- R7: Before any sync, the sample captured at the first edge after reset goes to port A when `PHASE_INIT` is 0 and to port B when it is 1, and the ports alternate from there.
- R8: `sync_in` is sampled on each rising edge; a falling edge means it was sampled high at edge j-1 and low at edge j. In dual-port mode the sample captured at edge j+1 then goes to port A and the sample at edge j+2 to port B.
- R9: A sync whose requested phase matches the running phase changes neither routing nor valid flags, so a sync toggling every clock (falling on alternate edges in step with the phase) is harmless.
- R10: A sync that conflicts with the running phase sends the sample at edge j+1 to port A with its valid flag low and the sample at edge j+2 to port B with its valid flag low; exactly those two samples are flagged.
- R11: Every sample that reaches a port and is not flagged under R10 carries a valid flag of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; samples captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| single_mode | input | 1 | 1 = all samples to port A; 0 = alternate between A and B |
| sync_in | input | 1 | Phase sync request; acts on a high-to-low transition |
| din | input | DATA_W | Converted sample |
| a_data | output | DATA_W | Port A sample |
| a_valid | output | 1 | Port A sample is not corrupted by a realignment |
| b_data | output | DATA_W | Port B sample |
| b_valid | output | 1 | Port B sample is not corrupted by a realignment |

## Verification
The bench builds two copies of the block with default widths and latencies (8-bit samples, 4 and 5 cycles), one with `PHASE_INIT` 0 and one with 1, driven by the same stimulus. Because the two start in opposite phases, the same first sync edge is a matching sync for one copy and a conflicting one for the other, so both the no-effect path and the corruption path are reached in one run. Every output of both copies is compared on every clock against a port and validity schedule computed from the sync levels, over a single-port run with and without sync activity and a dual-port run covering the unsynced start, a one-shot sync, a half-rate pulse train and a later deliberately conflicting sync.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  // Routing tag travelling alongside each sample through the latency line
  typedef struct packed {
    logic  occ;   // slot holds a captured sample
    port_e port;  // destination port
    logic  ok;    // sample not corrupted by a realignment
  } slot_t;

endpackage

// File: rtl/adc_sync_phase.sv
module adc_sync_phase
  import adc_demux_pkg::*;
#(
  parameter bit PHASE_INIT = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  single_mode,
  input  logic  sync_in,
  output port_e cap_port,
  output logic  cap_ok
);

  logic  sync_q1, sync_q2;
  logic  bad_pend;
  port_e ph;
  port_e ph_use;
  logic  fall_det;
  logic  conflict;

  // high sampled, then low sampled: falling edge seen this cycle
  assign fall_det = sync_q2 & ~sync_q1 & ~single_mode;
  assign ph_use   = fall_det ? PORT_A : ph;
  assign conflict = fall_det & (ph == PORT_B);
  assign cap_port = single_mode ? PORT_A : ph_use;
  assign cap_ok   = ~(conflict | bad_pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q1  <= 1'b0;
      sync_q2  <= 1'b0;
      ph       <= port_e'(PHASE_INIT);
      bad_pend <= 1'b0;
    end else begin
      sync_q1  <= sync_in;
      sync_q2  <= sync_q1;
      ph       <= (ph_use == PORT_A) ? PORT_B : PORT_A;
      bad_pend <= conflict;
    end
  end

  // R8
  sync_to_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!single_mode && !$past(rst) && !$past(rst, 2) &&
     $past(sync_in, 2) && !$past(sync_in)) |-> (cap_port == PORT_A));

  // R10
  bad_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!single_mode && bad_pend) |-> (cap_port == PORT_B && !cap_ok));

endmodule

// File: rtl/adc_lat_pipe.sv
module adc_lat_pipe
  import adc_demux_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5,
  parameter int TAP_S  = 3,
  parameter int TAP_D  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  slot_t             slot_in,
  output logic [DATA_W-1:0] tap_s_data,
  output slot_t             tap_s_slot,
  output logic [DATA_W-1:0] tap_d_data,
  output slot_t             tap_d_slot
);

  logic [DATA_W-1:0] data_q [DEPTH];
  slot_t             slot_q [DEPTH];

  // data stages carry no reset; the occupancy tag qualifies them
  always_ff @(posedge clk) begin
    data_q[0] <= din;
    for (int i = 1; i < DEPTH; i++) begin
      data_q[i] <= data_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_q[i] <= '0;
      end
    end else begin
      slot_q[0] <= slot_in;
      for (int i = 1; i < DEPTH; i++) begin
        slot_q[i] <= slot_q[i-1];
      end
    end
  end

  assign tap_s_data = data_q[TAP_S];
  assign tap_s_slot = slot_q[TAP_S];
  assign tap_d_data = data_q[TAP_D];
  assign tap_d_slot = slot_q[TAP_D];

endmodule

// File: rtl/adc_port_outs.sv
module adc_port_outs
  import adc_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_mode,
  input  slot_t             sel_slot,
  input  logic [DATA_W-1:0] sel_data,
  output logic [DATA_W-1:0] a_data,
  output logic              a_valid,
  output logic [DATA_W-1:0] b_data,
  output logic              b_valid
);

  logic a_upd, b_upd;

  assign a_upd = sel_slot.occ && (sel_slot.port == PORT_A);
  assign b_upd = sel_slot.occ && (sel_slot.port == PORT_B) && !single_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_data  <= '0;
      a_valid <= 1'b0;
      b_data  <= '0;
      b_valid <= 1'b0;
    end else begin
      if (a_upd) begin
        a_data  <= sel_data;
        a_valid <= sel_slot.ok;
      end
      if (b_upd) begin
        b_data  <= sel_data;
        b_valid <= sel_slot.ok;
      end
    end
  end

  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(single_mode) |-> ($stable(b_data) && $stable(b_valid)));

  // R11
  a_valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(a_valid) |-> !$past(single_mode));

  // R6
  b_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (!single_mode && $past(b_upd)) |-> !b_upd);

endmodule

// File: rtl/adc_port_demux.sv
module adc_port_demux
  import adc_demux_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LAT_SINGLE = 4,
  parameter int LAT_DUAL   = 5,
  parameter bit PHASE_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_mode,
  input  logic              sync_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] a_data,
  output logic              a_valid,
  output logic [DATA_W-1:0] b_data,
  output logic              b_valid
);

  localparam int DEPTH = (LAT_DUAL > LAT_SINGLE) ? LAT_DUAL : LAT_SINGLE;
  localparam int TAP_S = LAT_SINGLE - 1;
  localparam int TAP_D = LAT_DUAL - 1;

  port_e             cap_port;
  logic              cap_ok;
  slot_t             cap_slot;
  logic [DATA_W-1:0] tap_s_data, tap_d_data, sel_data;
  slot_t             tap_s_slot, tap_d_slot, sel_slot;

  adc_sync_phase #(
    .PHASE_INIT (PHASE_INIT)
  ) phase_i (
    .clk         (clk),
    .rst         (rst),
    .single_mode (single_mode),
    .sync_in     (sync_in),
    .cap_port    (cap_port),
    .cap_ok      (cap_ok)
  );

  assign cap_slot = '{occ: 1'b1, port: cap_port, ok: cap_ok};

  adc_lat_pipe #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .TAP_S  (TAP_S),
    .TAP_D  (TAP_D)
  ) pipe_i (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .slot_in    (cap_slot),
    .tap_s_data (tap_s_data),
    .tap_s_slot (tap_s_slot),
    .tap_d_data (tap_d_data),
    .tap_d_slot (tap_d_slot)
  );

  generate
    if (LAT_SINGLE == LAT_DUAL) begin : g_same_lat
      assign sel_data = tap_d_data;
      assign sel_slot = tap_d_slot;
    end else begin : g_mode_lat
      assign sel_data = single_mode ? tap_s_data : tap_d_data;
      assign sel_slot = single_mode ? tap_s_slot : tap_d_slot;
    end
  endgenerate

  adc_port_outs #(
    .DATA_W (DATA_W)
  ) outs_i (
    .clk         (clk),
    .rst         (rst),
    .single_mode (single_mode),
    .sel_slot    (sel_slot),
    .sel_data    (sel_data),
    .a_data      (a_data),
    .a_valid     (a_valid),
    .b_data      (b_data),
    .b_valid     (b_valid)
  );

endmodule

// File: tb/adc_port_demux_tb.sv
module adc_port_demux_tb_top;

  localparam int NMAX = 256;

  logic       clk = 1'b0;
  logic       rst;
  logic       single_mode;
  logic       sync_in;
  logic [7:0] din;

  logic [7:0] a_d [2];
  logic       a_v [2];
  logic [7:0] b_d [2];
  logic       b_v [2];

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 1'b0;

  // bench-side schedule
  logic  lvl   [NMAX];
  int    cport [2][NMAX];
  bit    cok   [2][NMAX];
  string ctag  [2][NMAX];
  int    nph   [2];
  bit    pend  [2];
  int    ea [2], eb [2];
  bit    eav [2], ebv [2];

  always #4 clk = ~clk;

  adc_port_demux #(.PHASE_INIT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .single_mode(single_mode), .sync_in(sync_in), .din(din),
    .a_data(a_d[0]), .a_valid(a_v[0]), .b_data(b_d[0]), .b_valid(b_v[0]));

  adc_port_demux #(.PHASE_INIT(1'b1)) dut_alt_i (
    .clk(clk), .rst(rst), .single_mode(single_mode), .sync_in(sync_in), .din(din),
    .a_data(a_d[1]), .a_valid(a_v[1]), .b_data(b_d[1]), .b_valid(b_v[1]));

  function automatic logic [7:0] dval(int c, int pidx);
    return 8'((c * 73 + 19 + pidx * 41) & 255);
  endfunction

  task automatic chk(string req, int inst, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s inst=%0d %s actual=%0d expected=%0d", req, inst, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic sched(bit smode, int e);
    if (smode) return (e > 20) && (e % 3 == 0);
    return (e == 13) || (e >= 41 && e <= 80 && (e % 2 == 1)) || (e == 92);
  endfunction

  function automatic string segtag(bit smode, int e);
    if (smode) return (e <= 20) ? "R2" : "R4";
    if (e < 15) return "R7";
    if (e < 41) return "R5";
    if (e < 94) return "R9";
    return "R10";
  endfunction

  task automatic run_phase(bit smode, int n, int pidx);
    rst = 1'b1;
    single_mode = smode;
    sync_in = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    // R1: outputs cleared by reset
    for (int i = 0; i < 2; i++) begin
      chk("R1", i, "a_data", a_d[i], 0);
      chk("R1", i, "b_data", b_d[i], 0);
      chk("R1", i, "a_valid", a_v[i], 0);
      chk("R1", i, "b_valid", b_v[i], 0);
      nph[i] = i;   // R7: start phase follows PHASE_INIT
      pend[i] = 1'b0;
      ea[i] = 0; eb[i] = 0; eav[i] = 1'b0; ebv[i] = 1'b0;
    end
    lvl[0] = 1'b0;
    rst = 1'b0;
    for (int e = 1; e <= n; e++) begin
      logic lv;
      int   lat;
      bit   fall;
      lv = sched(smode, e);
      din = dval(e, pidx);
      sync_in = lv;
      lvl[e] = lv;
      @(posedge clk);
      #2;
      // R8: falling edge = sampled high at e-2, low at e-1
      fall = (e >= 3) ? (lvl[e-2] && !lvl[e-1]) : 1'b0;
      for (int i = 0; i < 2; i++) begin
        ctag[i][e] = segtag(smode, e);
        if (smode) begin
          cport[i][e] = 0;
          cok[i][e] = 1'b1;
        end else if (fall) begin
          ctag[i][e] = "R8";
          cport[i][e] = 0;
          cok[i][e] = (nph[i] == 0);
          pend[i] = (nph[i] == 1);
          nph[i] = 1;
        end else begin
          cport[i][e] = nph[i];
          cok[i][e] = !pend[i];
          pend[i] = 1'b0;
          nph[i] = 1 - nph[i];
        end
      end
      lat = smode ? 4 : 5;
      for (int i = 0; i < 2; i++) begin
        int c;
        c = e - lat;
        if (c >= 1) begin
          if (cport[i][c] == 0) begin
            ea[i] = dval(c, pidx);
            eav[i] = cok[i][c];
            chk(ctag[i][c], i, "a_data", a_d[i], ea[i]);
            chk(eav[i] ? "R11" : "R10", i, "a_valid", a_v[i], eav[i]);
            chk(smode ? "R3" : "R6", i, "b_data", b_d[i], eb[i]);
            chk(smode ? "R3" : "R6", i, "b_valid", b_v[i], ebv[i]);
          end else begin
            eb[i] = dval(c, pidx);
            ebv[i] = cok[i][c];
            chk(ctag[i][c], i, "b_data", b_d[i], eb[i]);
            chk(ebv[i] ? "R11" : "R10", i, "b_valid", b_v[i], ebv[i]);
            chk("R6", i, "a_data", a_d[i], ea[i]);
            chk("R6", i, "a_valid", a_v[i], eav[i]);
          end
        end else begin
          chk("R1", i, "a_data", a_d[i], 0);
          chk("R1", i, "b_data", b_d[i], 0);
          chk("R1", i, "a_valid", a_v[i], 0);
          chk("R1", i, "b_valid", b_v[i], 0);
        end
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    single_mode = 1'b1;
    sync_in = 1'b0;
    din = '0;
    repeat (3) @(posedge clk);
    #2;
    run_phase(1'b1, 40, 0);
    run_phase(1'b0, 130, 1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule